// File: doc/BRIEF.md
# Module Power Mode Controller

This block decides how much power a pluggable four-lane module may draw. It merges a hardware low-power request pin with three software bits held in a one-byte control register and turns the result into a ceiling on the power class. It then moves the module between its low-power state and full operation. Each move takes a bounded, parameterised number of clock cycles, and a transition-busy flag is raised for as long as a move is under way.

The power ceiling comes from a small truth table. An override bit chooses which source rules: the pin or a software power-set bit. A separate high-class enable bit lifts the ceiling from class 4 to class 7. The class granted is the lower of that ceiling and the class the module advertises. The pin is asynchronous and passes through a synchroniser first. Going down to low power is quick when the pin asks for it and slower when software asks for it. Going up to full power is slower than either, and a downward request always wins over an upward one.

Top module: `power_mode_ctrl`

## Requirements
- R1: While reset is high and on the cycle after it, the granted class is 1, high-power enable is 0, busy is 0 and the control byte reads 0x00.
- R2: Control byte bit 0 is the override, bit 1 is the software power-set bit and bit 2 is the high-class enable. Bits 7..3 always read 0, and a write of 0xFF reads back 0x07.
- R3: With override 0, a pin level of 1 gives a ceiling of class 1. A pin level of 0 gives a ceiling of class 4, or class 7 when the high-class enable is 1.
- R4: With override 1, the pin has no effect. Power-set 1 gives a ceiling of class 1. Power-set 0 gives class 4, or class 7 when the high-class enable is 1.
- R5: The steady granted class is the minimum of the ceiling and the advertised class, with advertised 0 treated as 1. A module that advertises class 1 never raises busy or high-power enable.
- R6: A request to rise to full power raises busy for UP_CYC cycles while the class stays 1. After that, high-power enable rises, the granted class takes its target and busy falls.
- R7: With override 0, a rising pin in full power drops high-power enable one cycle after the pin leaves the synchroniser. The class returns to 1 DOWN_PIN_CYC cycles after that.
- R8: With override 1, setting power-set in full power drops high-power enable on the next cycle. The class returns to 1 after DOWN_SW_CYC cycles.
- R9: A request to go down that arrives while a move up is in progress ends the move up at once. If a move down is running and the cause of the drop becomes the pin, the remaining time is cut to DOWN_PIN_CYC. A request to go up during a move down restarts the full rise with the class set to 1.
- R10: In full power, a change of target between classes above 1 (for example, clearing the high-class enable caps class 7 at class 4) takes effect on the next cycle without raising busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_pin_i | input | 1 | Asynchronous low-power request pin, 1 requests low power |
| cfg_we_i | input | 1 | Write strobe for the control byte |
| cfg_wdata_i | input | 8 | Control byte write data |
| cfg_rdata_o | output | 8 | Control byte read-back |
| adv_class_i | input | 3 | Advertised maximum power class of the module (1..7) |
| grant_class_o | output | 3 | Highest power class currently allowed |
| hp_en_o | output | 1 | High-power enable to the module internals |
| busy_o | output | 1 | A power transition is in progress |

## Verification
A register write reaches the control byte on the first edge and the sequencer on the second edge. A pin change passes through SYNC_STAGES flops before the sequencer reacts on the next edge. Each move then adds exactly UP_CYC, DOWN_PIN_CYC or DOWN_SW_CYC further cycles. The bench drives on falling edges and counts those edges. It samples each output one edge before and at the edge on which it should change, so a latency that is off by one cycle in either direction is caught. Truth-table cases are checked only after a settling time longer than the slowest path.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef logic [2:0] pclass_t;

    // control byte layout: bit0 override, bit1 power-set, bit2 high-class enable
    typedef struct packed {
        logic hce;
        logic pset;
        logic ovr;
    } pmc_ctrl_t;

    typedef struct packed {
        logic    high;   // target lies above class 1
        logic    fast;   // a drop now would be pin-driven
        pclass_t cls;    // granted target class
    } pmc_target_t;

    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_UP   = 2'd1,
        ST_HIGH = 2'd2,
        ST_DOWN = 2'd3
    } pmc_state_t;

    localparam pclass_t CLASS_LOW   = 3'd1;
    localparam pclass_t CLASS_STD   = 3'd4;
    localparam pclass_t CLASS_EXTRA = 3'd7;

    function automatic pclass_t ceiling(input pmc_ctrl_t c, input logic pin);
        logic want_low;
        want_low = c.ovr ? c.pset : pin;
        if (want_low)
            return CLASS_LOW;
        return c.hce ? CLASS_EXTRA : CLASS_STD;
    endfunction

    function automatic pclass_t min_class(input pclass_t a, input pclass_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic pclass_t clamp_adv(input pclass_t a);
        return (a == 3'd0) ? CLASS_LOW : a;
    endfunction

endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output pmc_ctrl_t  ctrl,
    output logic [7:0] rdata
);
    pmc_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (we)
            ctrl_q <= pmc_ctrl_t'(wdata[2:0]);
    end

    assign ctrl  = ctrl_q;
    assign rdata = {5'b0, ctrl_q};

    // R2: a write lands in the defined bits on the next cycle
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> rdata[2:0] == $past(wdata[2:0]));

endmodule

// File: rtl/pmc_pin_sync.sv
module pmc_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= 1'b1;   // reset as "low power requested"
                else if (s == 0)
                    chain[s] <= pin_async;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign pin_sync = chain[STAGES-1];

endmodule

// File: rtl/pmc_policy.sv
module pmc_policy
    import pmc_pkg::*;
(
    input  pmc_ctrl_t   ctrl,
    input  logic        pin,
    input  pclass_t     adv_class,
    output pmc_target_t tgt
);
    pclass_t lim;
    pclass_t cls;

    always_comb begin
        lim      = ceiling(ctrl, pin);
        cls      = min_class(lim, clamp_adv(adv_class));
        tgt.cls  = cls;
        tgt.high = (cls > CLASS_LOW);
        tgt.fast = ~ctrl.ovr;
    end

endmodule

// File: rtl/pmc_sequencer.sv
module pmc_sequencer
    import pmc_pkg::*;
#(
    parameter int unsigned UP_CYC       = 60_000_000,
    parameter int unsigned DOWN_SW_CYC  = 20_000_000,
    parameter int unsigned DOWN_PIN_CYC = 20_000
) (
    input  logic        clk,
    input  logic        rst,
    input  pmc_target_t tgt,
    input  pclass_t     adv_class,
    output pclass_t     grant_class,
    output logic        hp_en,
    output logic        busy
);
    localparam int unsigned MAX_CYC = (UP_CYC > DOWN_SW_CYC)
                                    ? ((UP_CYC > DOWN_PIN_CYC) ? UP_CYC : DOWN_PIN_CYC)
                                    : ((DOWN_SW_CYC > DOWN_PIN_CYC) ? DOWN_SW_CYC : DOWN_PIN_CYC);
    localparam int unsigned CNT_W = $clog2(MAX_CYC + 1) + 1;
    localparam logic [CNT_W-1:0] UP_LOAD   = CNT_W'(UP_CYC - 1);
    localparam logic [CNT_W-1:0] SW_LOAD   = CNT_W'(DOWN_SW_CYC - 1);
    localparam logic [CNT_W-1:0] PIN_LOAD  = CNT_W'(DOWN_PIN_CYC - 1);

    pmc_state_t       st_q;
    logic [CNT_W-1:0] cnt_q;
    pclass_t          cls_q;
    logic             hp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_LOW;
            cnt_q <= '0;
            cls_q <= CLASS_LOW;
            hp_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_LOW: begin
                    cls_q <= CLASS_LOW;
                    hp_q  <= 1'b0;
                    if (tgt.high) begin
                        st_q  <= ST_UP;
                        cnt_q <= UP_LOAD;
                    end
                end
                ST_UP: begin
                    if (!tgt.high) begin
                        st_q <= ST_LOW;          // downward wins, nothing to undo
                    end else if (cnt_q == '0) begin
                        st_q  <= ST_HIGH;
                        hp_q  <= 1'b1;
                        cls_q <= tgt.cls;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (!tgt.high) begin
                        st_q  <= ST_DOWN;
                        hp_q  <= 1'b0;
                        cnt_q <= tgt.fast ? PIN_LOAD : SW_LOAD;
                    end else begin
                        cls_q <= tgt.cls;
                    end
                end
                ST_DOWN: begin
                    if (tgt.high) begin
                        st_q  <= ST_UP;
                        cls_q <= CLASS_LOW;
                        cnt_q <= UP_LOAD;
                    end else if (cnt_q == '0) begin
                        st_q  <= ST_LOW;
                        cls_q <= CLASS_LOW;
                    end else if (tgt.fast && cnt_q > PIN_LOAD) begin
                        cnt_q <= PIN_LOAD;       // pin bound is tighter
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= ST_LOW;
            endcase
        end
    end

    assign grant_class = cls_q;
    assign hp_en       = hp_q;
    assign busy        = (st_q == ST_UP) || (st_q == ST_DOWN);

    // R1: reset leaves the module in low power and idle
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> (grant_class == CLASS_LOW) && !hp_en && !busy);

    // R6: full power is only reached through a busy rise
    assert_rise_via_busy_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(hp_en) |-> $past(busy));

    // R6: high-power enable never coexists with the lowest class
    assert_hp_above_low_R6: assert property (@(posedge clk) disable iff (rst)
        hp_en |-> grant_class > CLASS_LOW);

    // R5: granted class never exceeds what the module advertised
    assert_class_cap_R5: assert property (@(posedge clk) disable iff (rst)
        hp_en |-> grant_class <= clamp_adv($past(adv_class)));

    // R7: class falls back to 1 only after high-power enable has been removed
    assert_drop_after_hp_R7: assert property (@(posedge clk) disable iff (rst)
        (grant_class == CLASS_LOW && $past(grant_class) != CLASS_LOW)
            |-> !hp_en && !$past(hp_en));

endmodule

// File: rtl/power_mode_ctrl.sv
module power_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned UP_CYC       = 60_000_000,
    parameter int unsigned DOWN_SW_CYC  = 20_000_000,
    parameter int unsigned DOWN_PIN_CYC = 20_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lp_pin_i,
    input  logic       cfg_we_i,
    input  logic [7:0] cfg_wdata_i,
    output logic [7:0] cfg_rdata_o,
    input  logic [2:0] adv_class_i,
    output logic [2:0] grant_class_o,
    output logic       hp_en_o,
    output logic       busy_o
);
    pmc_ctrl_t   ctrl;
    logic        pin_s;
    pmc_target_t tgt;

    pmc_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we_i),
        .wdata (cfg_wdata_i),
        .ctrl  (ctrl),
        .rdata (cfg_rdata_o)
    );

    pmc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (lp_pin_i),
        .pin_sync  (pin_s)
    );

    pmc_policy u_policy (
        .ctrl      (ctrl),
        .pin       (pin_s),
        .adv_class (adv_class_i),
        .tgt       (tgt)
    );

    pmc_sequencer #(
        .UP_CYC       (UP_CYC),
        .DOWN_SW_CYC  (DOWN_SW_CYC),
        .DOWN_PIN_CYC (DOWN_PIN_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tgt         (tgt),
        .adv_class   (adv_class_i),
        .grant_class (grant_class_o),
        .hp_en       (hp_en_o),
        .busy        (busy_o)
    );

endmodule

// File: tb/power_mode_ctrl_tb.sv
module power_mode_ctrl_tb_top;
    localparam int SY  = 2;
    localparam int UPC = 40;
    localparam int DSC = 24;
    localparam int DPC = 6;
    localparam int SETTLE = UPC + DSC + SY + 8;

    // vector: {ctrl[2:0] = {hce,pset,ovr}, pin, adv[2:0], expected class[2:0]}
    localparam logic [9:0] VEC [0:9] = '{
        {3'b100, 1'b1, 3'd7, 3'd1},   // R3 pin high -> class 1
        {3'b000, 1'b0, 3'd7, 3'd4},   // R3 pin low, no extra -> 4
        {3'b100, 1'b0, 3'd7, 3'd7},   // R3 pin low, extra -> 7
        {3'b100, 1'b0, 3'd5, 3'd5},   // R5 min with advertised
        {3'b000, 1'b0, 3'd3, 3'd3},   // R5 min with advertised
        {3'b111, 1'b0, 3'd7, 3'd1},   // R4 pset forces 1, pin ignored
        {3'b001, 1'b1, 3'd7, 3'd4},   // R4 pin high ignored -> 4
        {3'b101, 1'b1, 3'd6, 3'd6},   // R4 extra, advertised 6
        {3'b101, 1'b0, 3'd2, 3'd2},   // R5 advertised 2
        {3'b100, 1'b0, 3'd1, 3'd1}    // R5 advertised 1 stays low
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lp_pin = 1'b1;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] adv = 3'd7;
    logic [2:0] grant;
    logic       hp_en;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    power_mode_ctrl #(
        .SYNC_STAGES (SY),
        .UP_CYC      (UPC),
        .DOWN_SW_CYC (DSC),
        .DOWN_PIN_CYC(DPC)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .lp_pin_i     (lp_pin),
        .cfg_we_i     (we),
        .cfg_wdata_i  (wdata),
        .cfg_rdata_o  (rdata),
        .adv_class_i  (adv),
        .grant_class_o(grant),
        .hp_en_o      (hp_en),
        .busy_o       (busy)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write(input logic [7:0] d);
        we = 1'b1;
        wdata = d;
        step(1);
        we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(3);
        rst = 1'b0;
    endtask

    initial begin
        step(200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1: values during reset
        check("R1", "class in reset", int'(grant), 1);
        check("R1", "hp_en in reset", int'(hp_en), 0);
        rst = 1'b0;
        step(1);
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "ctrl after reset", int'(rdata), 0);

        // R2: reserved bits
        write(8'hFF);
        check("R2", "readback of 0xFF", int'(rdata), 8'h07);
        write(8'h00);
        check("R2", "readback of 0x00", int'(rdata), 0);

        // truth-table vectors at steady state
        for (int v = 0; v < 10; v++) begin
            lp_pin = VEC[v][6];
            adv    = VEC[v][5:3];
            write({5'b0, VEC[v][9:7]});
            step(SETTLE);
            check("R3/R4/R5", $sformatf("vector %0d class", v), int'(grant), int'(VEC[v][2:0]));
            check("R3/R4/R5", $sformatf("vector %0d hp_en", v), int'(hp_en), int'(VEC[v][2:0] > 3'd1));
        end

        // R6: rise timing through software
        do_reset();
        lp_pin = 1'b1;
        adv = 3'd7;
        step(2);
        write(8'h05);
        step(UPC);
        check("R6", "busy during rise", int'(busy), 1);
        check("R6", "hp_en during rise", int'(hp_en), 0);
        check("R6", "class during rise", int'(grant), 1);
        step(1);
        check("R6", "hp_en after rise", int'(hp_en), 1);
        check("R6", "class after rise", int'(grant), 7);
        check("R6", "busy after rise", int'(busy), 0);

        // R4: pin ignored under override
        lp_pin = 1'b0;
        step(5);
        lp_pin = 1'b1;
        step(20);
        check("R4", "class with pin toggled", int'(grant), 7);
        check("R4", "busy with pin toggled", int'(busy), 0);

        // R10: cap to 4 in full power
        write(8'h01);
        step(1);
        check("R10", "class capped", int'(grant), 4);
        check("R10", "busy on cap", int'(busy), 0);
        check("R10", "hp_en on cap", int'(hp_en), 1);

        // R8: software drop timing
        write(8'h03);
        step(1);
        check("R8", "hp_en at drop start", int'(hp_en), 0);
        step(DSC - 1);
        check("R8", "class before drop end", int'(grant), 4);
        check("R8", "busy before drop end", int'(busy), 1);
        step(1);
        check("R8", "class after drop", int'(grant), 1);
        check("R8", "busy after drop", int'(busy), 0);

        // R9: drop shortened once the pin becomes the cause
        write(8'h05);
        step(UPC + 1);
        check("R9", "back in full power", int'(hp_en), 1);
        write(8'h03);
        step(3);
        write(8'h00);
        step(DPC);
        check("R9", "busy before short end", int'(busy), 1);
        step(1);
        check("R9", "class after shortened drop", int'(grant), 1);
        check("R9", "busy after shortened drop", int'(busy), 0);

        // R7: pin-driven drop timing
        lp_pin = 1'b0;
        step(SY + UPC + 2);
        check("R3", "pin low rise class", int'(grant), 4);
        lp_pin = 1'b1;
        step(SY);
        check("R7", "hp_en before sync out", int'(hp_en), 1);
        step(1);
        check("R7", "hp_en after sync", int'(hp_en), 0);
        check("R7", "busy on pin drop", int'(busy), 1);
        step(DPC - 1);
        check("R7", "class before pin drop end", int'(grant), 4);
        step(1);
        check("R7", "class after pin drop", int'(grant), 1);
        check("R7", "busy after pin drop", int'(busy), 0);

        // R9: downward request cancels rise
        lp_pin = 1'b0;
        step(SY + 1);
        check("R9", "rise started", int'(busy), 1);
        step(5);
        lp_pin = 1'b1;
        step(SY);
        check("R9", "rise still busy", int'(busy), 1);
        step(1);
        check("R9", "rise cancelled", int'(busy), 0);
        check("R9", "class after cancel", int'(grant), 1);

        // R9: upward request during drop restarts rise
        lp_pin = 1'b0;
        step(SY + UPC + 2);
        check("R9", "full power again", int'(hp_en), 1);
        lp_pin = 1'b1;
        step(SY + 1);
        check("R9", "drop in progress", int'(busy), 1);
        step(2);
        lp_pin = 1'b0;
        step(SY);
        check("R9", "class held in drop", int'(grant), 4);
        step(1);
        check("R9", "restart class", int'(grant), 1);
        check("R9", "restart busy", int'(busy), 1);
        step(UPC);
        check("R9", "restart completes", int'(hp_en), 1);

        // R5: advertised class 1 never moves
        do_reset();
        adv = 3'd1;
        lp_pin = 1'b0;
        write(8'h04);
        begin
            int moved = 0;
            for (int c = 0; c < 200; c++) begin
                step(1);
                if (busy || hp_en) moved++;
            end
            check("R5", "cycles busy or high with class-1 module", moved, 0);
        end
        check("R5", "class-1 module grant", int'(grant), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule